// File: doc/BRIEF.md
# Error-Triggered Event Monitor Capture Controller

This controller decides which completed events are copied into a 128-slot monitoring buffer, and it decides when copying stops. Every event that finishes is offered on a one-cycle strobe along with an 8-bit vector of error conditions. A prescaler thins the offered stream so that only every N-th event is considered. The controller names the buffer slot in which each kept event belongs. The payload itself lives outside this block, so the controller only supplies a slot index and a write strobe.

There are two capture modes. When no trigger condition is enabled, the buffer fills once and stops when it is full. When one or more trigger conditions are enabled, the buffer runs as a ring and keeps overwriting its oldest events. This continues until a kept event carries an enabled error. The controller then keeps exactly 64 more events and freezes, so the buffer holds the history before and after the fault. Configuration and status share one 32-bit register. Any write to that register re-arms capture.

Top module: `evmon_ctrl`

## Requirements
- R1: After reset, the status word reads 0x00000000. Capture is armed in stop-on-full mode with a prescale field of 0, which stores every offered event.
- R2: `slot_we` is high only in a cycle in which `ev_valid` is high and the event is kept. `slot_idx` then equals the pointer field (status bits 14:8). After each kept event the pointer advances by one, and it returns from 127 to 0.
- R3: The prescale field (write bits 15:0) gives N = field + 1. After a re-arm, the offered events numbered N, 2N, 3N and so on are considered, and all other offered events are ignored.
- R4: When write bits 23:16 are all zero, the 128th kept event sets the full flag (status bit 15). No further event is kept until the next register write.
- R5: When any of write bits 23:16 is set, the pointer wraps from 127 to 0 and capture continues. The full flag still becomes set once 128 events have been kept.
- R6: In ring mode, a kept event that carries an enabled error starts the post-trigger window. Exactly 64 further events are kept, counted in status bits 7:0, which then read 0x40. Capture then stops. Errors on events inside the window do not restart the window.
- R7: Enable bit 16+i pairs with `ev_err[i]`. Bit 0 is the event/orbit/bunch counter mismatch, bit 1 is the CRC error, and bits 2 to 7 are spare conditions. An error whose enable bit is clear neither triggers nor is recorded.
- R8: Status bit 24+i becomes set, and stays set, when a kept event carries `ev_err[i]` with its enable set. This includes the trigger event and the events in the window. Events that are not kept leave these bits and the trigger unaffected.
- R9: Status bits 23:16 read back the enable byte as it was last written.
- R10: A register write clears the pointer, the full flag, the post-trigger count, the sticky bits and the prescale phase, and it restarts capture. An event offered in the same cycle as the write is not kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | One-cycle strobe: an event has completed |
| ev_err | input | 8 | Error conditions of the offered event (bit 0 counter mismatch, bit 1 CRC) |
| ctl_we | input | 1 | Control register write strobe (re-arms capture) |
| ctl_wdata | input | 32 | Write data: 23:16 trigger enables, 15:0 prescale field |
| ctl_rdata | output | 32 | Status: 31:24 sticky errors, 23:16 enables, 15 full, 14:8 pointer, 7:0 post count |
| slot_we | output | 1 | Kept event is written to the buffer this cycle |
| slot_idx | output | 7 | Buffer slot of the kept event |

## Verification
`slot_we` and `slot_idx` are combinational from the current event and the registered state. The bench therefore samples them in the same cycle the event is offered, two nanoseconds after it drives the inputs on the falling edge. The pointer, full flag, post-trigger count and sticky bits are registered, so each appears one rising edge after the event or write that changes it. The bench reads them one nanosecond after that edge. A cycle-level model in the bench, written from the requirements, supplies the expected values. Sweeps cover stop-on-full, several prescale ratios, ring wrap with disabled errors, a trigger followed by a full window, spare-condition triggers, and a write that coincides with an event.

// File: rtl/evmon_pkg.sv
package evmon_pkg;
   typedef enum logic [1:0] {
      CAP_RUN  = 2'd0,
      CAP_POST = 2'd1,
      CAP_HOLD = 2'd2
   } cap_state_e;

   localparam int STAT_PTR_W  = 7;
   localparam int STAT_CNT_W  = 8;
   localparam int STAT_ERR_W  = 8;
endpackage

// File: rtl/evmon_prescale.sv
module evmon_prescale #(
   parameter int PS_W   = 16,
   parameter bit USE_PS = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clr,
   input  logic            ev_valid,
   input  logic [PS_W-1:0] ratio,
   output logic            pick
);
   generate
      if (USE_PS) begin : g_count
         logic [PS_W-1:0] phase;
         logic            at_end;

         assign at_end = (phase == ratio);
         assign pick   = ev_valid & at_end;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               phase <= '0;
            end else if (clr) begin
               phase <= '0;
            end else if (ev_valid) begin
               phase <= at_end ? '0 : phase + 1'b1;
            end
         end
      end else begin : g_bypass
         logic unused_ps;
         assign unused_ps = ^{ratio, clk, rst_n, clr};
         assign pick      = ev_valid;
      end
   endgenerate
endmodule

// File: rtl/evmon_wptr.sv
module evmon_wptr #(
   parameter int DEPTH = 128,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          adv,
   output logic [AW-1:0] wptr,
   output logic          at_last,
   output logic          full
);
   assign at_last = (wptr == AW'(DEPTH - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wptr <= '0;
         full <= 1'b0;
      end else if (clr) begin
         wptr <= '0;
         full <= 1'b0;
      end else if (adv) begin
         if (at_last) begin
            wptr <= '0;
            full <= 1'b1;
         end else begin
            wptr <= wptr + 1'b1;
         end
      end
   end
endmodule

// File: rtl/evmon_seq.sv
module evmon_seq
   import evmon_pkg::*;
#(
   parameter int POST_LEN = 64,
   parameter int ERR_N    = 8,
   localparam int PCW     = $clog2(POST_LEN + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             pick,
   input  logic [ERR_N-1:0] err,
   input  logic [ERR_N-1:0] en,
   input  logic             at_last,
   output logic             store,
   output logic [PCW-1:0]   post_cnt,
   output logic [ERR_N-1:0] sticky
);
   cap_state_e state;
   logic       ring_mode;
   logic       hit;
   logic       window_done;

   assign ring_mode   = |en;
   assign hit         = |(err & en);
   assign window_done = (post_cnt == PCW'(POST_LEN - 1));
   assign store       = pick & (state != CAP_HOLD) & ~clr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= CAP_RUN;
         post_cnt <= '0;
      end else if (clr) begin
         state    <= CAP_RUN;
         post_cnt <= '0;
      end else if (store) begin
         unique case (state)
            CAP_RUN: begin
               if (ring_mode && hit) begin
                  state <= CAP_POST;
               end else if (!ring_mode && at_last) begin
                  state <= CAP_HOLD;
               end
            end
            CAP_POST: begin
               post_cnt <= post_cnt + 1'b1;
               if (window_done) begin
                  state <= CAP_HOLD;
               end
            end
            default: state <= CAP_HOLD;
         endcase
      end
   end

   generate
      for (genvar i = 0; i < ERR_N; i++) begin : g_sticky
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               sticky[i] <= 1'b0;
            end else if (clr) begin
               sticky[i] <= 1'b0;
            end else if (store && err[i] && en[i]) begin
               sticky[i] <= 1'b1;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/evmon_ctrl.sv
module evmon_ctrl
   import evmon_pkg::*;
#(
   parameter int DEPTH    = 128,
   parameter int POST_LEN = 64,
   parameter int PS_W     = 16,
   parameter bit USE_PS   = 1'b1,
   localparam int AW      = $clog2(DEPTH),
   localparam int ERR_N   = STAT_ERR_W,
   localparam int PCW     = $clog2(POST_LEN + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ev_valid,
   input  logic [ERR_N-1:0] ev_err,
   input  logic             ctl_we,
   input  logic [31:0]      ctl_wdata,
   output logic [31:0]      ctl_rdata,
   output logic             slot_we,
   output logic [STAT_PTR_W-1:0] slot_idx
);
   generate
      if (DEPTH < 2 || DEPTH > (1 << STAT_PTR_W)) begin : g_bad_depth
         $error("evmon_ctrl: DEPTH must lie in 2..128");
      end
      if (POST_LEN < 1 || POST_LEN > 255) begin : g_bad_post
         $error("evmon_ctrl: POST_LEN must lie in 1..255");
      end
      if (PS_W < 1 || PS_W > 16) begin : g_bad_ps
         $error("evmon_ctrl: PS_W must lie in 1..16");
      end
   endgenerate

   logic [ERR_N-1:0] en_q;
   logic [PS_W-1:0]  ratio_q;
   logic             pick;
   logic             store;
   logic [AW-1:0]    wptr;
   logic             at_last;
   logic             full;
   logic [PCW-1:0]   post_cnt;
   logic [ERR_N-1:0] sticky;
   logic             unused_wd;

   assign unused_wd = ^ctl_wdata[31:24];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q    <= '0;
         ratio_q <= '0;
      end else if (ctl_we) begin
         en_q    <= ctl_wdata[23:16];
         ratio_q <= ctl_wdata[PS_W-1:0];
      end
   end

   evmon_prescale #(.PS_W(PS_W), .USE_PS(USE_PS)) u_ps (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (ctl_we),
      .ev_valid (ev_valid),
      .ratio    (ratio_q),
      .pick     (pick)
   );

   evmon_seq #(.POST_LEN(POST_LEN), .ERR_N(ERR_N)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (ctl_we),
      .pick     (pick),
      .err      (ev_err),
      .en       (en_q),
      .at_last  (at_last),
      .store    (store),
      .post_cnt (post_cnt),
      .sticky   (sticky)
   );

   evmon_wptr #(.DEPTH(DEPTH)) u_wp (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (ctl_we),
      .adv     (store),
      .wptr    (wptr),
      .at_last (at_last),
      .full    (full)
   );

   assign slot_we   = store;
   assign slot_idx  = STAT_PTR_W'(wptr);
   assign ctl_rdata = {sticky, en_q, full, STAT_PTR_W'(wptr), STAT_CNT_W'(post_cnt)};
endmodule

// File: rtl/evmon_ctrl_chk.sv
module evmon_ctrl_chk #(
   parameter int DEPTH    = 128,
   parameter int POST_LEN = 64
) (
   input logic        clk,
   input logic        rst_n,
   input logic        ev_valid,
   input logic        ctl_we,
   input logic [31:0] ctl_wdata,
   input logic [31:0] ctl_rdata,
   input logic        slot_we,
   input logic [6:0]  slot_idx
);
   logic [6:0] next_idx;
   assign next_idx = (slot_idx == 7'(DEPTH - 1)) ? 7'd0 : slot_idx + 7'd1;

   // R2
   no_spurious_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ev_valid |-> !slot_we);

   // R2
   slot_matches_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      slot_we |-> slot_idx == ctl_rdata[14:8]);

   // R2
   ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      slot_we |=> ctl_rdata[14:8] == $past(next_idx));

   // R4
   full_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_rdata[15] && ctl_rdata[23:16] == 8'h00 && !ctl_we) |-> !slot_we);

   // R6
   window_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_rdata[7:0] == 8'(POST_LEN)) |-> !slot_we);

   // R6
   window_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_rdata[7:0] <= 8'(POST_LEN));

   // R8
   sticky_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_we |=> (ctl_rdata[31:24] & $past(ctl_rdata[31:24])) == $past(ctl_rdata[31:24]));

   // R9
   en_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_we |=> ctl_rdata[23:16] == $past(ctl_wdata[23:16]));

   // R10
   rearm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_we |=> (ctl_rdata[31:24] == 8'h00 && ctl_rdata[15:0] == 16'h0000));

   // R10
   rearm_no_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_we |-> !slot_we);
endmodule

bind evmon_ctrl evmon_ctrl_chk #(.DEPTH(DEPTH), .POST_LEN(POST_LEN)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ev_valid  (ev_valid),
   .ctl_we    (ctl_we),
   .ctl_wdata (ctl_wdata),
   .ctl_rdata (ctl_rdata),
   .slot_we   (slot_we),
   .slot_idx  (slot_idx)
);

// File: tb/tb_evmon_ctrl.sv
`timescale 1ns/1ps
module tb_evmon_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ev_valid = 1'b0;
   logic [7:0]  ev_err = 8'h00;
   logic        ctl_we = 1'b0;
   logic [31:0] ctl_wdata = 32'h0;
   logic [31:0] ctl_rdata;
   logic        slot_we;
   logic [6:0]  slot_idx;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   int         m_phase, m_ratio, m_wp, m_post, m_state;
   bit         m_full;
   logic [7:0] m_en, m_sticky;

   evmon_ctrl dut (
      .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_err(ev_err),
      .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
      .slot_we(slot_we), .slot_idx(slot_idx)
   );

   always #10 clk = ~clk;

   task automatic check(input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual 0x%08h expected 0x%08h", tag, what, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_status();
      return {m_sticky, m_en, m_full, 7'(m_wp), 8'(m_post)};
   endfunction

   task automatic model_clear(input logic [7:0] en, input int ratio);
      m_en = en; m_ratio = ratio; m_phase = 0; m_wp = 0; m_post = 0;
      m_state = 0; m_full = 1'b0; m_sticky = 8'h00;
   endtask

   task automatic wr(input logic [7:0] en, input int ratio, input string tag);
      @(negedge clk);
      ctl_we = 1'b1;
      ctl_wdata = {8'hA5, en, 16'(ratio)};
      @(posedge clk);
      #1 ctl_we = 1'b0;
      model_clear(en, ratio);
      check(tag, "status after write", ctl_rdata, exp_status());
   endtask

   task automatic offer(input logic [7:0] err, input string tag);
      bit pick, keep;
      @(negedge clk);
      ev_valid = 1'b1;
      ev_err = err;
      pick = (m_phase == m_ratio);
      m_phase = pick ? 0 : m_phase + 1;
      keep = pick && (m_state != 2);
      #2;
      check(tag, "slot_we", 32'(slot_we), 32'(keep));
      if (keep) check(tag, "slot_idx", 32'(slot_idx), 32'(m_wp));
      @(posedge clk);
      #1 ev_valid = 1'b0;
      ev_err = 8'h00;
      if (keep) begin
         m_sticky = m_sticky | (err & m_en);
         if (m_state == 1) begin
            m_post++;
            if (m_post == 64) m_state = 2;
         end else if (m_state == 0) begin
            if (m_en != 8'h00 && (err & m_en) != 8'h00) m_state = 1;
            else if (m_en == 8'h00 && m_wp == 127) m_state = 2;
         end
         if (m_wp == 127) m_full = 1'b1;
         m_wp = (m_wp + 1) % 128;
      end
      check(tag, "status", ctl_rdata, exp_status());
   endtask

   initial begin
      #(200000 * 20);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      model_clear(8'h00, 0);
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R1: reset state
      check("R1", "status after reset", ctl_rdata, 32'h0);
      check("R1", "slot_we idle", 32'(slot_we), 32'h0);
      offer(8'h00, "R1");

      // R2 R4: stop-on-full, pointer sequence, nothing kept after full
      wr(8'h00, 0, "R4");
      for (int i = 0; i < 132; i++) offer(8'h03, (i < 128) ? "R2" : "R4");
      check("R4", "full flag", 32'(ctl_rdata[15]), 32'h1);

      // R3: prescale sweep
      for (int ps = 1; ps <= 4; ps++) begin
         wr(8'h00, ps, "R3");
         for (int i = 0; i < 3 * (ps + 1) + 1; i++) offer(8'h00, "R3");
         check("R3", "kept count", 32'(ctl_rdata[14:8]), 32'(3));
      end

      // R5 R7: ring mode, CRC enabled, disabled errors do not trigger
      wr(8'h02, 0, "R9");
      for (int i = 0; i < 200; i++) offer((i % 3 == 0) ? 8'h05 : 8'h00, "R7");
      check("R5", "wrapped pointer", 32'(ctl_rdata[14:8]), 32'(200 % 128));
      check("R5", "full in ring", 32'(ctl_rdata[15]), 32'h1);
      check("R7", "no sticky from disabled", 32'(ctl_rdata[31:24]), 32'h0);
      // R6 R8: trigger then exactly 64 more
      offer(8'h02, "R6");
      check("R8", "sticky CRC", 32'(ctl_rdata[31:24]), 32'h02);
      for (int i = 0; i < 70; i++) offer((i == 5) ? 8'h03 : 8'h00, "R6");
      check("R6", "post count", 32'(ctl_rdata[7:0]), 32'h40);
      check("R6", "pointer", 32'(ctl_rdata[14:8]), 32'(265 % 128));

      // R8: errors on dropped events ignored (ratio 2, mismatch enabled)
      wr(8'h01, 1, "R8");
      for (int i = 0; i < 6; i++) offer((i % 2 == 0) ? 8'h01 : 8'h00, "R8");
      check("R8", "no trigger from dropped", 32'(ctl_rdata[31:24]), 32'h0);
      offer(8'h00, "R8");
      offer(8'h01, "R8");
      check("R8", "sticky mismatch", 32'(ctl_rdata[31:24]), 32'h01);
      for (int i = 0; i < 4; i++) offer(8'h00, "R6");
      check("R6", "window with prescale", 32'(ctl_rdata[7:0]), 32'h02);

      // R9 R7: spare enables read back and trigger
      wr(8'hF0, 0, "R9");
      check("R9", "enable readback", 32'(ctl_rdata[23:16]), 32'hF0);
      for (int i = 0; i < 10; i++) offer(8'h0F, "R7");
      offer(8'h30, "R7");
      check("R7", "spare sticky", 32'(ctl_rdata[31:24]), 32'h30);
      for (int i = 0; i < 66; i++) offer(8'h00, "R6");

      // R10: write in same cycle as event, then clean restart
      @(negedge clk);
      ctl_we = 1'b1;
      ctl_wdata = 32'h0000_0000;
      ev_valid = 1'b1;
      ev_err = 8'hFF;
      #2 check("R10", "slot_we during write", 32'(slot_we), 32'h0);
      @(posedge clk);
      #1 ctl_we = 1'b0;
      ev_valid = 1'b0;
      ev_err = 8'h00;
      model_clear(8'h00, 0);
      check("R10", "cleared status", ctl_rdata, 32'h0);
      offer(8'h00, "R10");
      check("R10", "restart at slot 0", 32'(ctl_rdata[14:8]), 32'h1);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule